// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

This block is a synchronous two-port RAM. Its two ports are called left and right, and each has its own chip enable, read/write line, output enable, address and data. Either port can read or write any word. The two highest words also act as mailboxes between the ports. When one port writes the other port's mailbox, an interrupt is raised toward that other port. The receiving port drops the interrupt by reading its own mailbox. The message itself is ordinary RAM data. It is written and read like any other word.

The right port's mailbox is the highest address. The left port's mailbox is the address just below it. Both addresses follow the address width, so a smaller configuration moves them down to the top of the smaller space. The `mbox_en_i` input turns the mailbox function off. While it is low, both words are plain RAM and no interrupt is ever raised.

All control inputs are active low. An access is a write when chip enable is low and read/write is low. It is a read when chip enable is low and read/write is high.

Top module: `dpram_mailbox`

## Requirements
- R1: While reset is asserted, and after it is released with no further access, both `lt_irq_no` and `rt_irq_no` are high (inactive).
- R2: A right-port write (ce low, we low) to address 2^ADDR_W-2 drives `lt_irq_no` low after the next rising clock edge, provided `mbox_en_i` is high.
- R3: A left-port write to address 2^ADDR_W-1 drives `rt_irq_no` low after the next rising clock edge, provided `mbox_en_i` is high.
- R4: A left-port access to 2^ADDR_W-2 with ce low and oe low drives `lt_irq_no` high after the next edge, whatever the read/write level. With oe high, the same access does not clear the flag.
- R5: A right-port read (ce low, we high, oe low) of 2^ADDR_W-1 drives `rt_irq_no` high after the next edge. A right-port write to that address, or a read with oe high, leaves the flag unchanged.
- R6: If a set and a clear of the same flag occur in one cycle, the flag ends up set.
- R7: Every word, the mailbox words included, stores the data written by either port. A read (ce low, we high) presents the word on that port's `*_rdata_o` after the next rising edge. The read data holds while the port does not read.
- R8: While `mbox_en_i` is low, both interrupt outputs go high after the next edge and stay high. Writes to either mailbox do not assert them, and the mailbox words still behave as RAM.
- R9: When one port reads a word in the same cycle that the other port writes it, the read returns the data stored before that write.
- R10: With chip enable high, a port neither writes the RAM nor sets or clears any flag.
- R11: A port writing its own mailbox, or either port accessing any other address, leaves both interrupt flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mbox_en_i | input | 1 | Mailbox interrupt enable |
| lt_ce_ni | input | 1 | Left chip enable, active low |
| lt_we_ni | input | 1 | Left read/write: low writes, high reads |
| lt_oe_ni | input | 1 | Left output enable, active low |
| lt_addr_i | input | ADDR_W | Left address |
| lt_wdata_i | input | DATA_W | Left write data |
| lt_rdata_o | output | DATA_W | Left read data, registered |
| lt_irq_no | output | 1 | Interrupt toward left port, active low |
| rt_ce_ni | input | 1 | Right chip enable, active low |
| rt_we_ni | input | 1 | Right read/write: low writes, high reads |
| rt_oe_ni | input | 1 | Right output enable, active low |
| rt_addr_i | input | ADDR_W | Right address |
| rt_wdata_i | input | DATA_W | Right write data |
| rt_rdata_o | output | DATA_W | Right read data, registered |
| rt_irq_no | output | 1 | Interrupt toward right port, active low |

## Verification
A flag's set and its clear can fall in the same cycle. To provoke this, the left flag is first raised. Then, in a single cycle, the right port writes the left mailbox while the left port performs its clearing access to that same mailbox. The flag must still be asserted after the edge. A read and a write to one word by the two ports in the same cycle is also provoked. The read port must show the value that was stored before that cycle, and a later read must show the new value.

// File: rtl/dpmb_pkg.sv
`timescale 1ns/1ps
package dpmb_pkg;
  typedef struct packed {
    logic wr;  // selected write
    logic rd;  // selected read
    logic oe;  // selected with output enable
  } acc_t;

  function automatic logic [31:0] mbox_hi(input int aw);
    return (32'd1 << aw) - 32'd1;
  endfunction

  function automatic logic [31:0] mbox_lo(input int aw);
    return (32'd1 << aw) - 32'd2;
  endfunction
endpackage

// File: rtl/dpmb_ram.sv
`timescale 1ns/1ps
module dpmb_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              lt_we_i,
  input  logic              lt_re_i,
  input  logic [ADDR_W-1:0] lt_addr_i,
  input  logic [DATA_W-1:0] lt_wdata_i,
  output logic [DATA_W-1:0] lt_rdata_o,
  input  logic              rt_we_i,
  input  logic              rt_re_i,
  input  logic [ADDR_W-1:0] rt_addr_i,
  input  logic [DATA_W-1:0] rt_wdata_i,
  output logic [DATA_W-1:0] rt_rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // right first, so left wins on a same-word double write
  always_ff @(posedge clk_i) begin
    if (rt_we_i) mem_q[rt_addr_i] <= rt_wdata_i;
    if (lt_we_i) mem_q[lt_addr_i] <= lt_wdata_i;
  end

  // read-before-write: nonblocking update gives old data
  always_ff @(posedge clk_i) begin
    if (lt_re_i) lt_rdata_o <= mem_q[lt_addr_i];
    if (rt_re_i) rt_rdata_o <= mem_q[rt_addr_i];
  end
endmodule

// File: rtl/dpmb_port_dec.sv
`timescale 1ns/1ps
module dpmb_port_dec
  import dpmb_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] OWN_MBOX  = '1,
  parameter logic [ADDR_W-1:0] PEER_MBOX = '0,
  parameter bit              CLR_ANY_RW = 1'b1
) (
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_t              acc_o,
  output logic              set_peer_o,
  output logic              clr_own_o
);
  logic hit_own, hit_peer;

  always_comb begin
    acc_o.wr = !ce_ni && !we_ni;
    acc_o.rd = !ce_ni &&  we_ni;
    acc_o.oe = !ce_ni && !oe_ni;
  end

  assign hit_own    = (addr_i == OWN_MBOX);
  assign hit_peer   = (addr_i == PEER_MBOX);
  assign set_peer_o = acc_o.wr && hit_peer;

  generate
    if (CLR_ANY_RW) begin : g_clr_any
      assign clr_own_o = acc_o.oe && hit_own;
    end else begin : g_clr_read
      assign clr_own_o = acc_o.oe && acc_o.rd && hit_own;
    end
  endgenerate
endmodule

// File: rtl/dpmb_irq_flag.sv
`timescale 1ns/1ps
module dpmb_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_no
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (!en_i)  flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;  // set beats clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign irq_no = ~flag_q;
endmodule

// File: rtl/dpram_mailbox.sv
`timescale 1ns/1ps
module dpram_mailbox
  import dpmb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mbox_en_i,
  input  logic              lt_ce_ni,
  input  logic              lt_we_ni,
  input  logic              lt_oe_ni,
  input  logic [ADDR_W-1:0] lt_addr_i,
  input  logic [DATA_W-1:0] lt_wdata_i,
  output logic [DATA_W-1:0] lt_rdata_o,
  output logic              lt_irq_no,
  input  logic              rt_ce_ni,
  input  logic              rt_we_ni,
  input  logic              rt_oe_ni,
  input  logic [ADDR_W-1:0] rt_addr_i,
  input  logic [DATA_W-1:0] rt_wdata_i,
  output logic [DATA_W-1:0] rt_rdata_o,
  output logic              rt_irq_no
);
  localparam logic [31:0]       MB_HI32 = mbox_hi(ADDR_W);
  localparam logic [31:0]       MB_LO32 = mbox_lo(ADDR_W);
  localparam logic [ADDR_W-1:0] MB_HI   = MB_HI32[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] MB_LO   = MB_LO32[ADDR_W-1:0];

  acc_t lt_acc, rt_acc;
  logic lt_set_rt, lt_clr_lt, rt_set_lt, rt_clr_rt;

  // left owns MB_LO, clears on ce+oe with any r/w level
  dpmb_port_dec #(
    .ADDR_W(ADDR_W), .OWN_MBOX(MB_LO), .PEER_MBOX(MB_HI), .CLR_ANY_RW(1'b1)
  ) u_lt_dec (
    .ce_ni(lt_ce_ni), .we_ni(lt_we_ni), .oe_ni(lt_oe_ni), .addr_i(lt_addr_i),
    .acc_o(lt_acc), .set_peer_o(lt_set_rt), .clr_own_o(lt_clr_lt)
  );

  // right owns MB_HI, clears only on an output-enabled read
  dpmb_port_dec #(
    .ADDR_W(ADDR_W), .OWN_MBOX(MB_HI), .PEER_MBOX(MB_LO), .CLR_ANY_RW(1'b0)
  ) u_rt_dec (
    .ce_ni(rt_ce_ni), .we_ni(rt_we_ni), .oe_ni(rt_oe_ni), .addr_i(rt_addr_i),
    .acc_o(rt_acc), .set_peer_o(rt_set_lt), .clr_own_o(rt_clr_rt)
  );

  dpmb_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk_i(clk_i),
    .lt_we_i(lt_acc.wr), .lt_re_i(lt_acc.rd), .lt_addr_i(lt_addr_i),
    .lt_wdata_i(lt_wdata_i), .lt_rdata_o(lt_rdata_o),
    .rt_we_i(rt_acc.wr), .rt_re_i(rt_acc.rd), .rt_addr_i(rt_addr_i),
    .rt_wdata_i(rt_wdata_i), .rt_rdata_o(rt_rdata_o)
  );

  dpmb_irq_flag u_lt_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(mbox_en_i),
    .set_i(rt_set_lt), .clr_i(lt_clr_lt), .irq_no(lt_irq_no)
  );

  dpmb_irq_flag u_rt_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(mbox_en_i),
    .set_i(lt_set_rt), .clr_i(rt_clr_rt), .irq_no(rt_irq_no)
  );
endmodule

// File: rtl/dpmb_chk.sv
`timescale 1ns/1ps
module dpmb_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mbox_en_i,
  input logic              lt_ce_ni,
  input logic              lt_we_ni,
  input logic              lt_oe_ni,
  input logic [ADDR_W-1:0] lt_addr_i,
  input logic              lt_irq_no,
  input logic              rt_ce_ni,
  input logic              rt_we_ni,
  input logic              rt_oe_ni,
  input logic [ADDR_W-1:0] rt_addr_i,
  input logic              rt_irq_no
);
  localparam logic [ADDR_W-1:0] HI = '1;
  localparam logic [ADDR_W-1:0] LO = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic c_set_lt, c_clr_lt, c_set_rt, c_clr_rt;
  assign c_set_lt = !rt_ce_ni && !rt_we_ni && rt_addr_i == LO;
  assign c_clr_lt = !lt_ce_ni && !lt_oe_ni && lt_addr_i == LO;
  assign c_set_rt = !lt_ce_ni && !lt_we_ni && lt_addr_i == HI;
  assign c_clr_rt = !rt_ce_ni && rt_we_ni && !rt_oe_ni && rt_addr_i == HI;

  p_rst_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (lt_irq_no && rt_irq_no));

  p_lt_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbox_en_i && c_set_lt) |=> !lt_irq_no);

  p_rt_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbox_en_i && c_set_rt) |=> !rt_irq_no);

  p_lt_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbox_en_i && c_clr_lt && !c_set_lt) |=> lt_irq_no);

  p_rt_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbox_en_i && c_clr_rt && !c_set_rt) |=> rt_irq_no);

  p_off_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mbox_en_i |=> (lt_irq_no && rt_irq_no));

  p_lt_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbox_en_i && !c_set_lt && !c_clr_lt) |=> $stable(lt_irq_no));

  p_rt_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbox_en_i && !c_set_rt && !c_clr_rt) |=> $stable(rt_irq_no));
endmodule

bind dpram_mailbox dpmb_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dpram_mailbox_tb_top.sv
`timescale 1ns/1ps
module dpram_mailbox_tb_top;
  localparam int AW = 12;
  localparam int DW = 18;
  localparam logic [AW-1:0] MB_HI = 12'hFFF;
  localparam logic [AW-1:0] MB_LO = 12'hFFE;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mbox_en_i = 1'b1;
  logic lt_ce_ni = 1'b1, lt_we_ni = 1'b1, lt_oe_ni = 1'b1;
  logic rt_ce_ni = 1'b1, rt_we_ni = 1'b1, rt_oe_ni = 1'b1;
  logic [AW-1:0] lt_addr_i = '0, rt_addr_i = '0;
  logic [DW-1:0] lt_wdata_i = '0, rt_wdata_i = '0;
  logic [DW-1:0] lt_rdata_o, rt_rdata_o;
  logic lt_irq_no, rt_irq_no;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  dpram_mailbox #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle();
    lt_ce_ni = 1'b1; lt_we_ni = 1'b1; lt_oe_ni = 1'b1;
    rt_ce_ni = 1'b1; rt_we_ni = 1'b1; rt_oe_ni = 1'b1;
  endtask

  task automatic lt_drv(input logic ce, input logic we, input logic oe,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
    lt_ce_ni = ce; lt_we_ni = we; lt_oe_ni = oe; lt_addr_i = a; lt_wdata_i = d;
  endtask

  task automatic rt_drv(input logic ce, input logic we, input logic oe,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
    rt_ce_ni = ce; rt_we_ni = we; rt_oe_ni = oe; rt_addr_i = a; rt_wdata_i = d;
  endtask

  task automatic t_reset();
    chk("R1", "lt_irq in reset", lt_irq_no, 1);
    chk("R1", "rt_irq in reset", rt_irq_no, 1);
    rst_ni = 1'b1;
    tick(); tick();
    chk("R1", "lt_irq after reset", lt_irq_no, 1);
    chk("R1", "rt_irq after reset", rt_irq_no, 1);
  endtask

  task automatic t_ram();
    lt_drv(0, 0, 1, 12'h010, 18'h2A5A5); rt_drv(0, 0, 1, 12'h020, 18'h15A5A);
    tick(); idle();
    lt_drv(0, 1, 0, 12'h020, '0); rt_drv(0, 1, 0, 12'h010, '0);
    tick(); idle();
    chk("R7", "lt reads rt word", lt_rdata_o, 18'h15A5A);
    chk("R7", "rt reads lt word", rt_rdata_o, 18'h2A5A5);
    tick();
    chk("R7", "lt rdata holds", lt_rdata_o, 18'h15A5A);
    chk("R11", "lt_irq untouched", lt_irq_no, 1);
    chk("R11", "rt_irq untouched", rt_irq_no, 1);
  endtask

  task automatic t_lt_flag();
    rt_drv(0, 0, 1, MB_LO, 18'h0BEEF);
    tick(); idle();
    chk("R2", "lt_irq set by rt write", lt_irq_no, 0);
    chk("R11", "rt_irq not set", rt_irq_no, 1);
    lt_drv(0, 1, 1, MB_LO, '0);  // read with oe high
    tick(); idle();
    chk("R4", "oe high keeps flag", lt_irq_no, 0);
    chk("R7", "lt mailbox data", lt_rdata_o, 18'h0BEEF);
    lt_drv(0, 0, 0, MB_LO, 18'h00123);  // write with oe low clears
    tick(); idle();
    chk("R4", "clear with rw low", lt_irq_no, 1);
    rt_drv(0, 0, 1, MB_LO, 18'h00777);
    tick(); idle();
    lt_drv(0, 1, 0, MB_LO, '0);
    tick(); idle();
    chk("R4", "clear with read", lt_irq_no, 1);
    chk("R7", "lt mailbox new data", lt_rdata_o, 18'h00777);
    lt_drv(0, 0, 1, MB_LO, 18'h00001);  // own mailbox write
    tick(); idle();
    chk("R11", "own mailbox write no set", lt_irq_no, 1);
  endtask

  task automatic t_rt_flag();
    lt_drv(0, 0, 1, MB_HI, 18'h3C3C3);
    tick(); idle();
    chk("R3", "rt_irq set by lt write", rt_irq_no, 0);
    chk("R11", "lt_irq not set", lt_irq_no, 1);
    rt_drv(0, 0, 0, MB_HI, 18'h11111);  // own write, no clear
    tick(); idle();
    chk("R5", "rt write keeps flag", rt_irq_no, 0);
    rt_drv(0, 1, 1, MB_HI, '0);  // read oe high
    tick(); idle();
    chk("R5", "read oe high keeps flag", rt_irq_no, 0);
    chk("R7", "rt mailbox data", rt_rdata_o, 18'h11111);
    rt_drv(0, 1, 0, MB_HI, '0);
    tick(); idle();
    chk("R5", "read clears", rt_irq_no, 1);
  endtask

  task automatic t_set_wins();
    rt_drv(0, 0, 1, MB_LO, 18'h00AAA);
    tick(); idle();
    chk("R6", "lt flag raised", lt_irq_no, 0);
    rt_drv(0, 0, 1, MB_LO, 18'h00BBB); lt_drv(0, 1, 0, MB_LO, '0);
    tick(); idle();
    chk("R6", "set wins over clear", lt_irq_no, 0);
    chk("R9", "clear read sees old", lt_rdata_o, 18'h00AAA);
    lt_drv(0, 1, 0, MB_LO, '0);
    tick(); idle();
    chk("R4", "later clear", lt_irq_no, 1);
    chk("R9", "later read new", lt_rdata_o, 18'h00BBB);
  endtask

  task automatic t_collide();
    lt_drv(0, 0, 1, 12'h055, 18'h01111);
    tick(); idle();
    rt_drv(0, 0, 1, 12'h055, 18'h02222); lt_drv(0, 1, 0, 12'h055, '0);
    tick(); idle();
    chk("R9", "read old on collision", lt_rdata_o, 18'h01111);
    lt_drv(0, 1, 0, 12'h055, '0);
    tick(); idle();
    chk("R9", "read new afterwards", lt_rdata_o, 18'h02222);
  endtask

  task automatic t_no_ce();
    rt_drv(1, 0, 0, MB_LO, 18'h3FFFF); lt_drv(1, 0, 0, MB_HI, 18'h3FFFF);
    tick(); idle();
    chk("R10", "no ce no lt set", lt_irq_no, 1);
    chk("R10", "no ce no rt set", rt_irq_no, 1);
    lt_drv(0, 1, 0, MB_LO, '0); rt_drv(0, 1, 1, MB_HI, '0);
    tick(); idle();
    chk("R10", "lt mailbox unwritten", lt_rdata_o, 18'h00BBB);
    chk("R10", "rt mailbox unwritten", rt_rdata_o, 18'h11111);
    rt_drv(0, 0, 1, MB_LO, 18'h00CCC);
    tick(); idle();
    lt_drv(1, 1, 0, MB_LO, '0);  // deselected clear attempt
    tick(); idle();
    chk("R10", "no ce no clear", lt_irq_no, 0);
    lt_drv(0, 1, 0, MB_LO, '0);
    tick(); idle();
    chk("R4", "cleanup clear", lt_irq_no, 1);
  endtask

  task automatic t_disable();
    rt_drv(0, 0, 1, MB_LO, 18'h00DDD);
    tick(); idle();
    chk("R8", "flag up before disable", lt_irq_no, 0);
    mbox_en_i = 1'b0;
    tick();
    chk("R8", "disable drops flag", lt_irq_no, 1);
    rt_drv(0, 0, 1, MB_LO, 18'h00EEE); lt_drv(0, 0, 1, MB_HI, 18'h00FFF);
    tick(); idle();
    chk("R8", "no lt set when off", lt_irq_no, 1);
    chk("R8", "no rt set when off", rt_irq_no, 1);
    lt_drv(0, 1, 0, MB_LO, '0); rt_drv(0, 1, 0, MB_HI, '0);
    tick(); idle();
    chk("R8", "lt mailbox as RAM", lt_rdata_o, 18'h00EEE);
    chk("R8", "rt mailbox as RAM", rt_rdata_o, 18'h00FFF);
    mbox_en_i = 1'b1;
    tick();
    chk("R8", "still clear on enable", lt_irq_no, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk_i);
    t_reset();
    t_ram();
    t_lt_flag();
    t_rt_flag();
    t_set_wins();
    t_collide();
    t_no_ce();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule